// File: doc/BRIEF.md
# Bus Access Self-Test Window

This block is a small memory-mapped target. Host software uses it to confirm that its own load and store paths produce the byte lanes, addresses and data it intends. Software stores a test number into a selector byte. The block then publishes what that test expects: an access width, a target offset inside the window and a data value. It also counts every host write that reproduces that pattern exactly and offers a short zero-terminated ASCII label for the test.

Tests are numbered without gaps from zero. A driver can therefore step the selector upward, run each test it understands, and stop at the first width code it does not recognise. No prior knowledge of the table is needed. The window spans up to 4 KB on a 32-bit bus that has per-byte enables. Reads return one cycle after the request.

Top module: `bus_selftest_window`

## Requirements
- R1: After reset the selected test is 0, the match counter is 0, `rd_valid` is low and `rd_data` is 0.
- R2: Word 0x0 reads {16'h0, width, 8'h00}: byte 1 holds the width code (1, 2 or 4) and bytes 0, 2 and 3 read zero. Table: test 0 = width 1, offset 0x100, data 0x5A, label "wr8"; test 1 = width 2, offset 0x202, data 0xA55A, label "wr16"; test 2 = width 4, offset 0x304, data 0x13579BDF, label "wr32"; test 3 = width 1, offset 0x403, data 0xC3, label "wr8hi".
- R3: Word 0x4 reads the selected test's target byte offset and word 0x8 its data value, both little endian.
- R4: For a selected test number of 4 or more, the width code reads 0xFF, offset and data read 0, and the label is empty.
- R5: A write to word 0x0 with byte enable 0 set loads the selector from write-data bits 7:0 and clears the counter in the same cycle.
- R6: A write increments the counter when three conditions hold. Its word address equals the target offset bits 11:2. Its byte enables equal exactly the lanes covering width bytes starting at lane offset[1:0]. Each enabled lane carries the matching byte of the data value, placed little endian from that lane.
- R7: A write that differs from the pattern in address, enables or any enabled data byte, and any read, leaves the counter unchanged.
- R8: The counter saturates at 2^CNT_W-1 and never wraps; word 0xC reads it zero-extended to 32 bits.
- R9: The label starts at byte 0x10, one character per byte in ascending address order, with a zero after the last character; label words beyond the table's label read zero.
- R10: A read in cycle t gives `rd_valid` high and the data in cycle t+1, `rd_valid` low otherwise. Reads of unused words return zero. Writes to words 0x4, 0x8, 0xC and to unused words change nothing.
- R11: Scanning the selector upward from 0 finds supported width codes for exactly tests 0 to 3 and an unsupported code at 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Transfer request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored, lanes come from `bus_be` |
| bus_be | input | 4 | Byte enables for writes, lane 0 = bits 7:0 |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, held between reads |
| rd_valid | output | 1 | High one cycle after a read request |

## Verification
Each test is driven with its exact pattern and then with near misses that differ in one thing only: a wrong data byte in an enabled lane, the right data at a neighbouring word, a wider or shifted enable mask, and a read at the target. The counter must move for the exact pattern and must not move for any near miss. That separates the address check, the lane-mask check and the data check. Reselection, an out-of-table test number and a long run of matching writes into a narrow counter cover clearing, the unsupported encoding and saturation. An upward scan confirms that the table has no gaps.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  localparam int NUM_TESTS  = 4;
  localparam int NAME_WORDS = 2;
  localparam int NAME_BITS  = 32 * NAME_WORDS;

  // header word indices (byte address / 4)
  localparam int W_CTRL  = 0;
  localparam int W_OFFS  = 1;
  localparam int W_VALUE = 2;
  localparam int W_COUNT = 3;
  localparam int W_NAME  = 4;

  localparam logic [7:0] WIDTH_NONE = 8'hFF;

  typedef struct packed {
    logic [7:0]           width;
    logic [31:0]          offset;
    logic [31:0]          value;
    logic [NAME_BITS-1:0] name;   // byte 0 = first character
  } test_desc_t;

  // Label literals are written back to front so the first character
  // lands in the least significant byte (little endian in the window).
  function automatic test_desc_t lookup(input logic [7:0] num);
    test_desc_t d;
    d.width  = WIDTH_NONE;
    d.offset = '0;
    d.value  = '0;
    d.name   = '0;
    case (num)
      8'd0: begin
        d.width = 8'd1; d.offset = 32'h0000_0100; d.value = 32'h0000_005A;
        d.name  = {40'h0, "8rw"};
      end
      8'd1: begin
        d.width = 8'd2; d.offset = 32'h0000_0202; d.value = 32'h0000_A55A;
        d.name  = {32'h0, "61rw"};
      end
      8'd2: begin
        d.width = 8'd4; d.offset = 32'h0000_0304; d.value = 32'h1357_9BDF;
        d.name  = {32'h0, "23rw"};
      end
      8'd3: begin
        d.width = 8'd1; d.offset = 32'h0000_0403; d.value = 32'h0000_00C3;
        d.name  = {24'h0, "ih8rw"};
      end
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/sbt_match.sv
module sbt_match
  import sbt_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  input  test_desc_t        desc,
  output logic              sel_wr,
  output logic              hit
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic [3:0]        exp_be;
  logic [31:0]       exp_word;
  logic [3:0]        lane_ok;
  logic              addr_ok;
  logic              wr;

  assign widx = bus_addr[ADDR_W-1:2];
  assign wr   = bus_valid && bus_write;

  // lanes a correct access of the advertised width must enable
  always_comb begin
    case (desc.width)
      8'd1:    exp_be = 4'b0001 << desc.offset[1:0];
      8'd2:    exp_be = 4'b0011 << desc.offset[1:0];
      8'd4:    exp_be = 4'b1111;
      default: exp_be = 4'b0000;
    endcase
    exp_word = desc.value << {desc.offset[1:0], 3'b000};
  end

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign lane_ok[i] = !exp_be[i] || (bus_wdata[8*i +: 8] == exp_word[8*i +: 8]);
  end

  assign addr_ok = (desc.offset[31:ADDR_W] == '0) &&
                   (desc.offset[ADDR_W-1:2] == widx);

  assign sel_wr = wr && (widx == WIDX_W'(W_CTRL)) && bus_be[0];
  assign hit    = wr && (exp_be != 4'b0000) && (bus_be == exp_be) &&
                  addr_ok && (&lane_ok);

  // R6: no table target overlaps the selector, so both never fire together
  assert_hit_excl_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_wr, hit}));

  // R7: a read never counts
  assert_read_nohit_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |-> !hit);

endmodule

// File: rtl/sbt_satcnt.sv
module sbt_satcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                       count <= '0;
    else if (clr)                  count <= '0;
    else if (inc && count != MAX)  count <= count + 1'b1;
  end

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && count != MAX) |=> (count == $past(count) + 1'b1));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (!clr && count == MAX) |=> (count == MAX));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(count));

endmodule

// File: rtl/sbt_rdport.sv
module sbt_rdport
  import sbt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  test_desc_t        desc,
  input  logic [CNT_W-1:0]  count,
  output logic [31:0]       rd_data,
  output logic              rd_valid
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic [31:0]       word;

  assign widx = rd_addr[ADDR_W-1:2];

  always_comb begin
    word = '0;
    if (widx == WIDX_W'(W_CTRL))  word = {16'h0, desc.width, 8'h00};
    if (widx == WIDX_W'(W_OFFS))  word = desc.offset;
    if (widx == WIDX_W'(W_VALUE)) word = desc.value;
    if (widx == WIDX_W'(W_COUNT)) word = 32'(count);
    for (int k = 0; k < NAME_WORDS; k++) begin
      if (widx == WIDX_W'(W_NAME + k)) word = desc.name[32*k +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word;
    end
  end

  assert_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_rquiet_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && $stable(rd_data)));

endmodule

// File: rtl/bus_selftest_window.sv
module bus_selftest_window
  import sbt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       rd_data,
  output logic              rd_valid
);

  logic [7:0]       sel_q;
  test_desc_t       desc;
  logic             sel_wr;
  logic             hit;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= 8'd0;
    else if (sel_wr) sel_q <= bus_wdata[7:0];
  end

  assign desc = lookup(sel_q);

  sbt_match #(.ADDR_W(ADDR_W)) u_match (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .desc      (desc),
    .sel_wr    (sel_wr),
    .hit       (hit)
  );

  sbt_satcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (sel_wr),
    .inc   (hit),
    .count (count)
  );

  sbt_rdport #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (bus_valid && !bus_write),
    .rd_addr  (bus_addr),
    .desc     (desc),
    .count    (count),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assert_sel_load_R5: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> (sel_q == $past(bus_wdata[7:0])));

  assert_sel_keep_R10: assert property (@(posedge clk) disable iff (rst)
    !sel_wr |=> $stable(sel_q));

endmodule

// File: tb/bus_selftest_window_bench.sv
module bus_selftest_window_bench;

  localparam int ADDR_W = 12;
  localparam int CNT_W  = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr  = '0;
  logic [3:0]        bus_be    = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       rd_data;
  logic              rd_valid;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bus_selftest_window #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bus_selftest_window (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // ---------------- reference table, written from the requirements ----
  function automatic int t_width(int n);
    case (n) 0: return 1; 1: return 2; 2: return 4; 3: return 1; default: return 255; endcase
  endfunction
  function automatic int t_off(int n);
    case (n) 0: return 'h100; 1: return 'h202; 2: return 'h304; 3: return 'h403; default: return 0; endcase
  endfunction
  function automatic int t_dat(int n);
    case (n) 0: return 'h5A; 1: return 'hA55A; 2: return 'h13579BDF; 3: return 'hC3; default: return 0; endcase
  endfunction
  function automatic string t_name(int n);
    case (n) 0: return "wr8"; 1: return "wr16"; 2: return "wr32"; 3: return "wr8hi"; default: return ""; endcase
  endfunction

  function automatic logic [31:0] model_read(int sel, int cnt, int addr);
    int w;
    logic [31:0] r;
    string s;
    w = addr / 4;
    r = 0;
    s = t_name(sel);
    case (w)
      0: r[15:8] = 8'(t_width(sel));
      1: r = 32'(t_off(sel));
      2: r = 32'(t_dat(sel));
      3: r = 32'(cnt);
      default: ;
    endcase
    if (w >= 4 && w < 6) begin
      for (int b = 0; b < 4; b++) begin
        int k = (w - 4) * 4 + b;
        if (k < s.len()) r[8*b +: 8] = s[k];
      end
    end
    return r;
  endfunction

  // byte-by-byte comparison against the advertised access
  function automatic bit model_match(int sel, int addr, logic [3:0] be, logic [31:0] d);
    int w, o, v;
    bit ok;
    w = t_width(sel);
    o = t_off(sel);
    v = t_dat(sel);
    if (!(w == 1 || w == 2 || w == 4)) return 0;
    ok = 1;
    for (int b = 0; b < 4; b++) begin
      int a = (addr / 4) * 4 + b;
      bit want = (a >= o) && (a < o + w);
      if (be[b] != want) ok = 0;
      if (want && d[8*b +: 8] != 8'((v >> (8 * (a - o))) & 'hFF)) ok = 0;
    end
    return ok;
  endfunction

  // ---------------- cycle model ----------------
  int          m_sel = 0;
  int          m_cnt = 0;
  logic        e_rvalid = 1'b0;
  logic [31:0] e_rdata  = '0;
  string       cur_tag = "R10";
  string       e_tag   = "R10";

  always @(posedge clk) begin
    if (rst) begin
      m_sel <= 0; m_cnt <= 0; e_rvalid <= 1'b0; e_rdata <= '0;
    end else begin
      e_rvalid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) begin
        e_rdata <= model_read(m_sel, m_cnt, int'(bus_addr));
        e_tag   <= cur_tag;
      end
      if (bus_valid && bus_write) begin
        if (bus_addr[ADDR_W-1:2] == 0 && bus_be[0]) begin
          m_sel <= int'(bus_wdata[7:0]);
          m_cnt <= 0;
        end else if (model_match(m_sel, int'(bus_addr), bus_be, bus_wdata)) begin
          m_cnt <= (m_cnt == CMAX) ? CMAX : m_cnt + 1;
        end
      end
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compared on every falling edge
  always @(negedge clk) begin
    if (rst) begin
      check(rd_valid == 1'b0, "R1", 32'(rd_valid), 0);
      check(rd_data == 32'h0, "R1", rd_data, 0);
    end else begin
      check(rd_valid == e_rvalid, "R10", 32'(rd_valid), 32'(e_rvalid));
      if (e_rvalid) check(rd_data == e_rdata, e_tag, rd_data, e_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(int addr, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = ADDR_W'(addr); bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(int addr, string tag);
    @(negedge clk);
    cur_tag = tag;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = ADDR_W'(addr); bus_be = 4'h0;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic select(int n);
    wr(0, 4'b0001, 32'(n));
  endtask

  task automatic hit_write(int n);
    int o = t_off(n);
    logic [3:0] be;
    case (t_width(n)) 1: be = 4'b0001 << (o % 4); 2: be = 4'b0011 << (o % 4); default: be = 4'b1111; endcase
    wr((o / 4) * 4, be, 32'(t_dat(n)) << (8 * (o % 4)));
  endtask

  task automatic read_header(string t);
    rd(0, "R2"); rd(4, "R3"); rd(8, "R3"); rd(12, t); rd(16, "R9"); rd(20, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    rd(12, "R1");
    rd(0, "R1");

    // every table entry: header, label, one exact hit
    for (int n = 0; n < 4; n++) begin
      select(n);
      read_header("R5");
      hit_write(n);
      rd(12, "R6");
    end

    // near misses for test 0 (offset 0x100, lane 0, data 0x5A)
    select(0);
    wr('h100, 4'b0001, 32'h5B);     rd(12, "R7");
    wr('h104, 4'b0001, 32'h5A);     rd(12, "R7");
    wr('h100, 4'b0011, 32'h5A);     rd(12, "R7");
    wr('h100, 4'b0010, 32'h5A00);   rd(12, "R7");
    rd('h100, "R10");               rd(12, "R7");
    wr('h100, 4'b0001, 32'hFFFF_FF5A); rd(12, "R6");
    // near misses for test 1 (lanes 2-3)
    select(1);
    wr('h200, 4'b1100, 32'hA55B_0000); rd(12, "R7");
    wr('h200, 4'b1111, 32'hA55A_0000); rd(12, "R7");
    wr('h200, 4'b1100, 32'hA55A_1234); rd(12, "R6");

    // read-only and unused words ignore writes
    wr(4, 4'hF, 32'hFFFF_FFFF);
    wr(8, 4'hF, 32'hFFFF_FFFF);
    wr(12, 4'hF, 32'hFFFF_FFFF);
    wr('h800, 4'hF, 32'hFFFF_FFFF);
    wr(0, 4'b1110, 32'h0000_0003);
    read_header("R10");
    rd('h800, "R10"); rd('hFFC, "R10"); rd(24, "R10");

    // out-of-table test
    select(7);
    read_header("R4");
    hit_write(0);
    rd(12, "R4");
    select(255);
    read_header("R4");

    // saturation and reselect clearing
    select(2);
    for (int i = 0; i < CMAX + 5; i++) hit_write(2);
    rd(12, "R8");
    select(2);
    rd(12, "R5");

    // upward scan
    begin
      int found = 0;
      for (int n = 0; n < 16; n++) begin
        int wc;
        select(n);
        rd(0, "R11");
        wc = int'(rd_data[15:8]);
        if (wc == 1 || wc == 2 || wc == 4) found++;
        else break;
      end
      check(found == 4, "R11", 32'(found), 32'd4);
    end

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule